// File: doc/BRIEF.md
# Compressed Table-Jump Execution Unit

This unit carries out the 16-bit table-jump instruction for a RISC-V core. It keeps a software-visible jump-vector-table register. When a matching instruction arrives, the unit adds an 8-bit index taken from the instruction to the table base held in that register. It reads the selected table entry through a single-word memory port and then emits a one-cycle PC redirect to the entry value with bit 0 cleared. Indices of 32 and above select the linking form, which also writes the return address (PC+2) into register x1.

The table register is reached through a CSR port at address 0x017. The low six bits of the register are a mode field, and only mode zero allows the jump. The table base is the register with those six bits masked off; it is not shifted. The extension-enable input gates both the CSR and the instruction. When the unit is built for a privileged configuration, a state-enable grant input gates them as well. A denied access reports the cause that the state-enable check supplies.

Top module: `tbljmp_unit`

## Requirements
- R1: An instruction is accepted only while `ins_ready` is high and `ins_word` has bits[15:13]=101, bits[12:10]=000 and bits[1:0]=10; any other word causes no memory read, no exception and no redirect. The table index is bits[9:2].
- R2: A CSR access with `csr_addr`=0x017 answers one cycle later with `csr_rvalid`=1 and `csr_rdata` holding the value stored before the access; a permitted write stores all XLEN bits unchanged. Other CSR addresses get no answer. The register resets to zero.
- R3: A CSR access while `ext_en`=0 answers `csr_err`=1 with `csr_cause`=2 (illegal instruction). With PRIV_EN set and `se_grant`=0 it answers `csr_err`=1 with `csr_cause`=`se_cause`. A denied write leaves the register unchanged.
- R4: The table read address is (register with bits[5:0] cleared) + index*XLEN/8, modulo 2^XLEN, and exactly one read is issued for each accepted instruction.
- R5: If the register's bits[5:0] are nonzero, an accepted instruction pulses `exc_valid` with `exc_cause`=2 one cycle after acceptance and issues no read and no redirect.
- R6: When the read is acknowledged without a fault, `redir_valid` is high for exactly the one cycle after the acknowledge, with `redir_pc` = read data with bit 0 cleared.
- R7: For an index of 32 or more, `rf_we` pulses in the same cycle as the redirect with `rf_waddr`=1 and `rf_wdata` = instruction PC + 2. For an index below 32, `rf_we` stays low.
- R8: A read acknowledged with `mem_fault`=1 pulses `exc_valid` with `exc_cause`=1 in the cycle after the acknowledge, and produces no redirect and no register write.
- R9: An accepted instruction while `ext_en`=0 raises `exc_cause`=2. With PRIV_EN set and `se_grant`=0 it raises `exc_cause`=`se_cause`. In both cases no read is issued.
- R10: `mem_req` rises the cycle after acceptance and stays high with a stable `mem_addr` until the cycle of `mem_ack`, then falls.
- R11: `ins_ready` is low while a read is outstanding, and instructions presented then are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_en | input | 1 | Table-jump extension enabled |
| se_grant | input | 1 | State-enable grant for the table register |
| se_cause | input | 5 | Cause to report when the grant is missing |
| ins_valid | input | 1 | Decoded instruction present |
| ins_word | input | 16 | Instruction word |
| ins_pc | input | XLEN | PC of the instruction |
| ins_ready | output | 1 | Unit idle, can accept |
| csr_req | input | 1 | CSR access strobe |
| csr_we | input | 1 | CSR write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rvalid | output | 1 | CSR answer valid |
| csr_rdata | output | XLEN | CSR read data |
| csr_err | output | 1 | CSR access denied |
| csr_cause | output | 5 | Cause of a denied CSR access |
| mem_req | output | 1 | Table read request |
| mem_addr | output | XLEN | Table entry address |
| mem_ack | input | 1 | Read completes |
| mem_rdata | input | XLEN | Table entry data |
| mem_fault | input | 1 | Read failed |
| rf_we | output | 1 | Link register write |
| rf_waddr | output | 5 | Link register index |
| rf_wdata | output | XLEN | Return address |
| redir_valid | output | 1 | PC redirect pulse |
| redir_pc | output | XLEN | New PC |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 5 | Exception cause |

## Verification
The bench runs all 256 indices against three table bases: zero, a base with mid-range bits set, and a base near the top of the address space. The index sweep separates a correct index-times-four offset from shifting or truncation errors. It also exposes the linking boundary at 31/32, and the high base shows whether the base is masked rather than shifted. Read latencies of zero to two cycles are mixed in, and a second instruction is presented while busy, to confirm the request holding and busy blocking. All 63 nonzero modes are tried with each base-bit pattern to confirm that the mode check covers each bit. Denial by extension-enable, denial by state-enable, a faulting read and near-miss instruction encodings separate the priority of the checks and the suppression of the redirect and the link write.

// File: rtl/tj_pkg.sv
package tj_pkg;
    typedef enum logic {ST_IDLE, ST_FETCH} tj_state_e;

    localparam logic [4:0]  CAUSE_ILLEGAL   = 5'd2;
    localparam logic [4:0]  CAUSE_TBL_FAULT = 5'd1;
    localparam logic [11:0] CSR_TBL_ADDR    = 12'h017;
    localparam int          MODE_BITS       = 6;
    localparam int          LINK_FIRST_IDX  = 32;
    localparam logic [4:0]  LINK_REG        = 5'd1;
endpackage

// File: rtl/tj_decode.sv
module tj_decode (
    input  logic [15:0] word,
    output logic        hit,
    output logic [7:0]  idx,
    output logic        link
);
    always_comb begin
        hit  = (word[15:13] == 3'b101) && (word[12:10] == 3'b000) && (word[1:0] == 2'b10);
        idx  = word[9:2];
        link = (int'(word[9:2]) >= tj_pkg::LINK_FIRST_IDX);
    end
endmodule

// File: rtl/tj_addr.sv
module tj_addr #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] tbl_reg,
    input  logic [7:0]      idx,
    output logic [XLEN-1:0] addr,
    output logic            mode_bad
);
    localparam int MB = tj_pkg::MODE_BITS;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offs;

    always_comb begin
        base     = {tbl_reg[XLEN-1:MB], {MB{1'b0}}};
        mode_bad = |tbl_reg[MB-1:0];
    end

    generate
        if (XLEN == 64) begin : g_dword
            always_comb offs = {{(XLEN-11){1'b0}}, idx, 3'b000};
        end else begin : g_word
            always_comb offs = {{(XLEN-10){1'b0}}, idx, 2'b00};
        end
    endgenerate

    always_comb addr = base + offs;
endmodule

// File: rtl/tj_csr.sv
module tj_csr #(
    parameter int XLEN    = 32,
    parameter bit PRIV_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_en,
    input  logic            se_grant,
    input  logic [4:0]      se_cause,
    input  logic            req,
    input  logic            we,
    input  logic [11:0]     addr,
    input  logic [XLEN-1:0] wdata,
    output logic            rvalid,
    output logic [XLEN-1:0] rdata,
    output logic            err,
    output logic [4:0]      cause,
    output logic [XLEN-1:0] value
);
    typedef struct packed {
        logic [XLEN-1:0] value;
        logic            rvalid;
        logic [XLEN-1:0] rdata;
        logic            err;
        logic [4:0]      cause;
    } csr_t;

    csr_t r_q, r_d;

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        if (req && addr == tj_pkg::CSR_TBL_ADDR) begin
            r_d.rvalid = 1'b1;
            if (!ext_en) begin
                r_d.err   = 1'b1;
                r_d.cause = tj_pkg::CAUSE_ILLEGAL;
                r_d.rdata = '0;
            end else if (PRIV_EN && !se_grant) begin
                r_d.err   = 1'b1;
                r_d.cause = se_cause;
                r_d.rdata = '0;
            end else begin
                r_d.err   = 1'b0;
                r_d.cause = '0;
                r_d.rdata = r_q.value;
                if (we) r_d.value = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rvalid = r_q.rvalid;
    assign rdata  = r_q.rdata;
    assign err    = r_q.err;
    assign cause  = r_q.cause;
    assign value  = r_q.value;
endmodule

// File: rtl/tbljmp_unit.sv
module tbljmp_unit #(
    parameter int XLEN    = 32,
    parameter bit PRIV_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_en,
    input  logic            se_grant,
    input  logic [4:0]      se_cause,
    input  logic            ins_valid,
    input  logic [15:0]     ins_word,
    input  logic [XLEN-1:0] ins_pc,
    output logic            ins_ready,
    input  logic            csr_req,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic            csr_rvalid,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_err,
    output logic [4:0]      csr_cause,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr,
    input  logic            mem_ack,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_fault,
    output logic            rf_we,
    output logic [4:0]      rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            redir_valid,
    output logic [XLEN-1:0] redir_pc,
    output logic            exc_valid,
    output logic [4:0]      exc_cause
);
    import tj_pkg::*;

    typedef struct packed {
        tj_state_e       st;
        logic            req;
        logic [XLEN-1:0] addr;
        logic            link;
        logic [XLEN-1:0] ret;
        logic            redir_v;
        logic [XLEN-1:0] redir_pc;
        logic            rf_we;
        logic            exc_v;
        logic [4:0]      exc_cause;
    } ctl_t;

    ctl_t r_q, r_d;

    logic            dec_hit, dec_link, mode_bad;
    logic [7:0]      dec_idx;
    logic [XLEN-1:0] tbl_reg, tbl_addr;

    tj_decode u_dec (
        .word (ins_word),
        .hit  (dec_hit),
        .idx  (dec_idx),
        .link (dec_link)
    );

    tj_addr #(.XLEN(XLEN)) u_addr (
        .tbl_reg  (tbl_reg),
        .idx      (dec_idx),
        .addr     (tbl_addr),
        .mode_bad (mode_bad)
    );

    tj_csr #(.XLEN(XLEN), .PRIV_EN(PRIV_EN)) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_en   (ext_en),
        .se_grant (se_grant),
        .se_cause (se_cause),
        .req      (csr_req),
        .we       (csr_we),
        .addr     (csr_addr),
        .wdata    (csr_wdata),
        .rvalid   (csr_rvalid),
        .rdata    (csr_rdata),
        .err      (csr_err),
        .cause    (csr_cause),
        .value    (tbl_reg)
    );

    always_comb begin
        r_d         = r_q;
        r_d.redir_v = 1'b0;
        r_d.rf_we   = 1'b0;
        r_d.exc_v   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (ins_valid && dec_hit) begin
                    if (!ext_en) begin
                        r_d.exc_v     = 1'b1;
                        r_d.exc_cause = CAUSE_ILLEGAL;
                    end else if (PRIV_EN && !se_grant) begin
                        r_d.exc_v     = 1'b1;
                        r_d.exc_cause = se_cause;
                    end else if (mode_bad) begin
                        r_d.exc_v     = 1'b1;
                        r_d.exc_cause = CAUSE_ILLEGAL;
                    end else begin
                        r_d.st   = ST_FETCH;
                        r_d.req  = 1'b1;
                        r_d.addr = tbl_addr;
                        r_d.link = dec_link;
                        r_d.ret  = ins_pc + XLEN'(2);
                    end
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    r_d.st  = ST_IDLE;
                    r_d.req = 1'b0;
                    if (mem_fault) begin
                        r_d.exc_v     = 1'b1;
                        r_d.exc_cause = CAUSE_TBL_FAULT;
                    end else begin
                        r_d.redir_v  = 1'b1;
                        r_d.redir_pc = {mem_rdata[XLEN-1:1], 1'b0};
                        r_d.rf_we    = r_q.link;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ins_ready   = (r_q.st == ST_IDLE);
    assign mem_req     = r_q.req;
    assign mem_addr    = r_q.addr;
    assign rf_we       = r_q.rf_we;
    assign rf_waddr    = LINK_REG;
    assign rf_wdata    = r_q.ret;
    assign redir_valid = r_q.redir_v;
    assign redir_pc    = r_q.redir_pc;
    assign exc_valid   = r_q.exc_v;
    assign exc_cause   = r_q.exc_cause;
endmodule

// File: rtl/tbljmp_unit_chk.sv
module tbljmp_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ins_ready,
    input logic            mem_req,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_ack,
    input logic            rf_we,
    input logic [4:0]      rf_waddr,
    input logic            redir_valid,
    input logic            exc_valid
);
    // R6: the redirect lasts a single cycle
    a_r6_redir_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !redir_valid);

    // R10: the request holds its address until acknowledged
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R10: the request drops after the acknowledge
    a_r10_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    // R7: a link write comes only with a redirect, into x1
    a_r7_link_with_redir: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (redir_valid && rf_waddr == 5'd1));

    // R8: an exception never comes together with a redirect or a pending read
    a_r8_exc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (!redir_valid && !mem_req));

    // R4: table addresses are entry aligned
    a_r4_addr_align: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R11: busy while a read is outstanding
    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !ins_ready);
endmodule

bind tbljmp_unit tbljmp_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_ready   (ins_ready),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .rf_we       (rf_we),
    .rf_waddr    (rf_waddr),
    .redir_valid (redir_valid),
    .exc_valid   (exc_valid)
);

// File: tb/tbljmp_unit_bench.sv
module tbljmp_unit_bench;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ext_en = 1'b1, se_grant = 1'b1;
    logic [4:0]      se_cause = 5'd22;
    logic            ins_valid = 1'b0;
    logic [15:0]     ins_word = '0;
    logic [XLEN-1:0] ins_pc = '0;
    logic            ins_ready;
    logic            csr_req = 1'b0, csr_we = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic            csr_rvalid, csr_err;
    logic [XLEN-1:0] csr_rdata;
    logic [4:0]      csr_cause;
    logic            mem_req;
    logic [XLEN-1:0] mem_addr;
    logic            mem_ack = 1'b0, mem_fault = 1'b0;
    logic [XLEN-1:0] mem_rdata = '0;
    logic            rf_we, redir_valid, exc_valid;
    logic [4:0]      rf_waddr, exc_cause;
    logic [XLEN-1:0] rf_wdata, redir_pc;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tbljmp_unit #(.XLEN(XLEN), .PRIV_EN(1'b1)) u_tbljmp_unit (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_word(input logic [7:0] idx);
        return {3'b101, 3'b000, idx, 2'b10};
    endfunction

    function automatic logic [XLEN-1:0] entry(input logic [XLEN-1:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1357_9BDF;
    endfunction

    task automatic csr_op(input bit we, input logic [11:0] a, input logic [XLEN-1:0] wd);
        @(negedge clk);
        csr_req = 1'b1; csr_we = we; csr_addr = a; csr_wdata = wd;
        @(negedge clk);
        csr_req = 1'b0; csr_we = 1'b0;
    endtask

    task automatic csr_wr(input logic [XLEN-1:0] wd);
        csr_op(1'b1, 12'h017, wd);
    endtask

    task automatic csr_expect(input logic [XLEN-1:0] exp, input string req);
        csr_op(1'b0, 12'h017, '0);
        chk(csr_rvalid && !csr_err, req, {31'b0, csr_err, csr_rvalid}, 64'h1);
        chk(csr_rdata == exp, req, csr_rdata, exp);
    endtask

    // Run one table jump that is expected to reach the memory port.
    task automatic run_jump(input logic [XLEN-1:0] base, input logic [7:0] idx,
                            input logic [XLEN-1:0] pc, input int lat, input bit fault);
        logic [XLEN-1:0] ea, dat;
        ea  = {base[XLEN-1:6], 6'b0} + {22'b0, idx, 2'b00};
        dat = entry(ea);
        @(negedge clk);
        ins_valid = 1'b1; ins_word = mk_word(idx); ins_pc = pc;
        @(negedge clk);
        ins_valid = 1'b0;
        chk(mem_req, "R10 request raised", mem_req, 1);
        chk(mem_addr == ea, "R4 table address", mem_addr, ea);
        for (int k = 0; k < lat; k++) begin
            ins_valid = 1'b1; ins_word = mk_word(8'd77); // ignored while busy
            @(negedge clk);
            ins_valid = 1'b0;
            chk(mem_req && mem_addr == ea, "R10 request held", mem_addr, ea);
            chk(!ins_ready, "R11 busy", ins_ready, 0);
        end
        mem_ack = 1'b1; mem_rdata = dat; mem_fault = fault;
        @(negedge clk);
        mem_ack = 1'b0; mem_fault = 1'b0;
        chk(!mem_req, "R10 request dropped", mem_req, 0);
        if (fault) begin
            chk(exc_valid && exc_cause == 5'd1, "R8 fault cause", {exc_valid, exc_cause}, {1'b1, 5'd1});
            chk(!redir_valid && !rf_we, "R8 no redirect or link", {redir_valid, rf_we}, 0);
        end else begin
            chk(redir_valid && !exc_valid, "R6 redirect pulse", {redir_valid, exc_valid}, 2'b10);
            chk(redir_pc == {dat[XLEN-1:1], 1'b0}, "R6 target", redir_pc, {dat[XLEN-1:1], 1'b0});
            if (idx >= 8'd32) begin
                chk(rf_we && rf_waddr == 5'd1 && rf_wdata == pc + 2, "R7 link write",
                    rf_wdata, pc + 2);
            end else begin
                chk(!rf_we, "R7 no link below 32", rf_we, 0);
            end
        end
        @(negedge clk);
        chk(!redir_valid && !rf_we && !exc_valid && !mem_req, "R11 busy instruction ignored / R6 one cycle",
            {redir_valid, rf_we, exc_valid, mem_req}, 0);
    endtask

    // Instruction expected to be refused without any read.
    task automatic run_refused(input logic [15:0] w, input bit exp_exc, input logic [4:0] exp_cause, input string req);
        @(negedge clk);
        ins_valid = 1'b1; ins_word = w; ins_pc = 32'h100;
        @(negedge clk);
        ins_valid = 1'b0;
        chk(!mem_req && !redir_valid, req, {mem_req, redir_valid}, 0);
        chk(exc_valid == exp_exc && (!exp_exc || exc_cause == exp_cause), req,
            {exc_valid, exc_cause}, {exp_exc, exp_cause});
        @(negedge clk);
        chk(!mem_req && !exc_valid, req, {mem_req, exc_valid}, 0);
    endtask

    initial begin
        logic [XLEN-1:0] bases [3];
        bases[0] = 32'h0; bases[1] = 32'h0000_1040; bases[2] = 32'hFFFF_F000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ins_ready && !mem_req && !redir_valid && !exc_valid && !rf_we, "R2 reset outputs",
            {ins_ready, mem_req, redir_valid, exc_valid, rf_we}, 5'b10000);
        csr_expect('0, "R2 reset value");

        // R2 full-width store, other address ignored
        csr_wr(32'hDEAD_BEEF);
        csr_expect(32'hDEAD_BEEF, "R2 write/read");
        csr_op(1'b0, 12'h018, '0);
        chk(!csr_rvalid, "R2 other address", csr_rvalid, 0);

        // R4 R6 R7 R10 R11 full sweep
        foreach (bases[b]) begin
            csr_wr(bases[b]);
            for (int i = 0; i < 256; i++)
                run_jump(bases[b], 8'(i), 32'h8000_0000 + 32'(i * 6), i % 3, 1'b0);
        end

        // R8 faults for linking and plain forms
        csr_wr(32'h0000_2000);
        run_jump(32'h0000_2000, 8'd40, 32'h400, 1, 1'b1);
        run_jump(32'h0000_2000, 8'd3, 32'h400, 0, 1'b1);

        // R5 every nonzero mode
        for (int m = 1; m < 64; m++) begin
            csr_wr(32'h0000_2000 | 32'(m));
            run_refused(mk_word(8'd5), 1'b1, 5'd2, "R5 mode fault");
        end
        csr_wr(32'h0000_2000);

        // R1 near-miss encodings
        run_refused(16'b101_001_00000101_10, 1'b0, 5'd0, "R1 bits12:10");
        run_refused(16'b101_000_00000101_01, 1'b0, 5'd0, "R1 bits1:0");
        run_refused(16'b100_000_00000101_10, 1'b0, 5'd0, "R1 bits15:13");

        // R9 R3 extension disabled
        ext_en = 1'b0;
        run_refused(mk_word(8'd50), 1'b1, 5'd2, "R9 ext disabled");
        csr_op(1'b1, 12'h017, 32'h5555_0000);
        chk(csr_rvalid && csr_err && csr_cause == 5'd2, "R3 ext disabled csr", csr_cause, 5'd2);
        ext_en = 1'b1;
        csr_expect(32'h0000_2000, "R3 denied write kept");

        // R9 R3 state-enable denied
        se_grant = 1'b0;
        run_refused(mk_word(8'd50), 1'b1, 5'd22, "R9 state-enable denied");
        csr_op(1'b1, 12'h017, 32'h7777_0000);
        chk(csr_rvalid && csr_err && csr_cause == 5'd22, "R3 state-enable csr", csr_cause, 5'd22);
        se_grant = 1'b1;
        csr_expect(32'h0000_2000, "R3 denied write kept");

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule